// File: doc/BRIEF.md
# Digital Signal-Level Gain Loop

This block sits behind a pulse-shaping filter and keeps the level of the filtered I and Q samples near a programmable target. For every accepted sample pair it forms the instantaneous power I² + Q² and smooths it with a first-order leaky average. The smoothed estimate is compared with the target, and the signed error is scaled by a gain picked from a 3-bit code and added into a clamped 16-bit integrator. The upper byte of the integrator is an unsigned gain in 2.6 fixed point. That gain multiplies the I sample and the Q sample alike, and both results saturate to 8-bit signed outputs.

A byte-wide register port reaches the control byte, which holds the code, the target, and the integrator as separate high and low bytes. The integrator can be read at any time. Once the loop settles, its value stands for the power in the useful band. Writing the integrator presets the gain. A code of zero freezes the loop, which turns the block into a fixed, programmable gain stage.

Top module: `sig_agc`

## Requirements
- R1: After reset the integrator reads 0x4000 (unity gain of 64/64), and the code, the target, the power average, out_valid, out_i and out_q are all zero.
- R2: Register map, with reads combinational on reg_addr: address 0 is control, with the code in bits [7:5]; its bits [4:0] are not stored and read as zero. Address 1 is integrator bits [15:8], address 2 is integrator bits [7:0], and address 3 is the 8-bit target m2. A write takes effect at the next clock edge.
- R3: On each cycle with in_valid high, the power average A is updated to A + ((I² + Q² − A) >>> 4), using signed arithmetic with floor shifting. Without in_valid, A holds.
- R4: Code 1, 2, 3, 4 or 5 gives an integrator gain of 1, 4, 16, 64 or 256. Code 0 gives gain 0, and codes 6 and 7 are also treated as gain 0.
- R5: With gain 0, the integrator keeps its value across valid samples.
- R6: On a valid sample with a nonzero gain, the integrator becomes clamp(G + ((m2·64 − A)·beta >>> 8), 0, 65535). Here A is the average before the current sample, and m2 and beta are the values held before this edge.
- R7: Writing address 1 loads the data into the integrator's high byte and clears its low byte. Writing address 2 replaces only the low byte. An integrator write takes priority over the loop update in the same cycle.
- R8: One cycle after a valid sample, out_valid is high and each output equals sat((x · G[15:8]) >>> 6) to the range −128..127. G is the integrator value before that edge, and I and Q use the same gain.
- R9: When in_valid is low, out_valid is low in the following cycle and out_i and out_q keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample pair qualifier |
| in_i | input | 8 | Filtered in-phase sample, signed |
| in_q | input | 8 | Filtered quadrature sample, signed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| out_valid | output | 1 | Output pair qualifier |
| out_i | output | 8 | Scaled in-phase sample, signed |
| out_q | output | 8 | Scaled quadrature sample, signed |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 16-bit integrator and average, a leak shift of 4, an error shift of 8 and 6 fractional gain bits. With 8-bit samples, full-scale inputs drive the integrator to both clamp rails within a few samples at the largest code. A gain byte of 0xFF pushes both outputs into positive and negative saturation, so every rail of the datapath is reached with short directed runs. Long random runs with occasional register writes then check the loop arithmetic against a bench model.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_IHI  = 2'd1,
        ADR_ILO  = 2'd2,
        ADR_TGT  = 2'd3
    } agc_addr_e;

    typedef logic [2:0] agc_code_t;

    localparam int unsigned CODE_MAX_VALID = 5;
    localparam int unsigned MAX_SHIFT      = 8;
endpackage

// File: rtl/agc_coef_dec.sv
module agc_coef_dec
    import agc_pkg::*;
#(
    parameter int SH_W = 4
) (
    input  agc_code_t         code,
    output logic              en,
    output logic [SH_W-1:0]   shift
);
    always_comb begin
        en    = (code != 3'd0) && (32'(code) <= CODE_MAX_VALID);
        shift = en ? SH_W'({code - 3'd1, 1'b0}) : '0;
    end

    always_comb begin
        if (en) begin
            a_shift_even_r4: assert (shift[0] == 1'b0 && 32'(shift) <= MAX_SHIFT)
                else $error("coefficient shift out of range");
        end
    end
endmodule

// File: rtl/agc_power_est.sv
module agc_power_est #(
    parameter int DW  = 8,
    parameter int AW  = 16,
    parameter int SH  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic signed [DW-1:0] smp_i,
    input  logic signed [DW-1:0] smp_q,
    output logic [AW-1:0]        avg
);
    localparam int PW     = 2*DW + 2;
    localparam int DIFF_W = ((PW > AW+1) ? PW : AW+1) + 1;

    typedef struct packed {
        logic [AW-1:0] avg;
    } pe_st_t;

    pe_st_t st_d, st_q;
    logic signed [PW-1:0]     i_x, q_x, pwr;
    logic signed [DIFF_W-1:0] avg_s, diff, nxt;

    always_comb begin
        st_d  = st_q;
        i_x   = PW'(smp_i);
        q_x   = PW'(smp_q);
        pwr   = i_x*i_x + q_x*q_x;
        avg_s = DIFF_W'($signed({1'b0, st_q.avg}));
        diff  = DIFF_W'(pwr) - avg_s;
        nxt   = avg_s + (diff >>> SH);
        if (vld) st_d.avg = nxt[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg = st_q.avg;

    p_rise_toward_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld && (DIFF_W'(pwr) >= avg_s) |=> avg >= $past(avg));
    p_fall_toward_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld && (DIFF_W'(pwr) <= avg_s) |=> avg <= $past(avg));
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator #(
    parameter int           AW      = 16,
    parameter int           IW      = 16,
    parameter int           TGT_W   = 8,
    parameter int           TGT_SH  = 6,
    parameter int           ERR_SH  = 8,
    parameter int           SH_W    = 4,
    parameter int           MAX_SH  = 8,
    parameter logic [IW-1:0] RST_VAL = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [AW-1:0]     avg,
    input  logic [TGT_W-1:0]  tgt,
    input  logic              en,
    input  logic [SH_W-1:0]   shift,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [IW/2-1:0]   wdata,
    output logic [IW-1:0]     intg
);
    localparam int HB     = IW/2;
    localparam int ERR_W  = AW + 2;
    localparam int STEP_W = ERR_W + MAX_SH + 1;
    localparam int SUM_W  = STEP_W + 1;

    typedef struct packed {
        logic [IW-1:0] intg;
    } it_st_t;

    it_st_t st_d, st_q;
    logic signed [ERR_W-1:0]  err;
    logic signed [STEP_W-1:0] step;
    logic signed [SUM_W-1:0]  sum;
    logic [IW-1:0]            clamped;

    always_comb begin
        st_d = st_q;
        err  = ERR_W'($signed({1'b0, tgt, {TGT_SH{1'b0}}}))
             - ERR_W'($signed({1'b0, avg}));
        step = (STEP_W'(err) <<< shift) >>> ERR_SH;
        sum  = SUM_W'($signed({1'b0, st_q.intg})) + SUM_W'(step);
        if (sum < 0)
            clamped = '0;
        else if (sum > SUM_W'($signed({1'b0, {IW{1'b1}}})))
            clamped = '1;
        else
            clamped = sum[IW-1:0];

        if (wr_hi)
            st_d.intg = {wdata, {HB{1'b0}}};
        else if (wr_lo)
            st_d.intg = {st_q.intg[IW-1:HB], wdata};
        else if (vld && en)
            st_d.intg = clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.intg <= RST_VAL;
        else        st_q      <= st_d;
    end

    assign intg = st_q.intg;

    p_hold_gain0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !en && !wr_hi && !wr_lo |=> $stable(intg));
    p_hi_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (intg[HB-1:0] == '0) && (intg[IW-1:HB] == $past(wdata)));
    p_up_when_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld && en && !wr_hi && !wr_lo && (err > 0) |=> intg >= $past(intg));
    p_down_when_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld && en && !wr_hi && !wr_lo && (err < 0) |=> intg <= $past(intg));
endmodule

// File: rtl/agc_gain_mult.sv
module agc_gain_mult #(
    parameter int DW   = 8,
    parameter int GW   = 8,
    parameter int FRAC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic signed [DW-1:0] x,
    input  logic [GW-1:0]        gain,
    output logic signed [DW-1:0] y
);
    localparam int PW = DW + GW + 1;
    localparam logic signed [PW-1:0] MAXV = $signed({{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [PW-1:0] MINV = $signed({{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}});

    typedef struct packed {
        logic [DW-1:0] y;
    } gm_st_t;

    gm_st_t st_d, st_q;
    logic signed [PW-1:0] prod, shd;

    always_comb begin
        st_d = st_q;
        prod = PW'(x) * PW'($signed({1'b0, gain}));
        shd  = prod >>> FRAC;
        if (vld) begin
            if (shd > MAXV)      st_d.y = MAXV[DW-1:0];
            else if (shd < MINV) st_d.y = MINV[DW-1:0];
            else                 st_d.y = shd[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y = $signed(st_q.y);

    p_unity_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vld && (gain == GW'(1 << FRAC)) |=> y == $past(x));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(y));
endmodule

// File: rtl/sig_agc.sv
module sig_agc
    import agc_pkg::*;
#(
    parameter int            DATA_W  = 8,
    parameter int            AVG_W   = 16,
    parameter int            INT_W   = 16,
    parameter int            LEAK_SH = 4,
    parameter int            ERR_SH  = 8,
    parameter int            TGT_SH  = 6,
    parameter int            FRAC_W  = 6,
    parameter logic [15:0]   INT_RST = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    localparam int BYTE_W = 8;
    localparam int GAIN_W = INT_W / 2;
    localparam int SH_W   = 4;
    localparam int LANES  = 2;

    typedef struct packed {
        agc_code_t         code;
        logic [BYTE_W-1:0] tgt;
        logic              ovld;
    } top_st_t;

    top_st_t st_d, st_q;
    agc_addr_e adr;
    logic wr_ctrl, wr_ihi, wr_ilo, wr_tgt;
    logic [AVG_W-1:0] avg;
    logic [INT_W-1:0] intg;
    logic             dec_en;
    logic [SH_W-1:0]  dec_shift;
    logic signed [DATA_W-1:0] lane_x [LANES];
    logic signed [DATA_W-1:0] lane_y [LANES];

    always_comb begin
        adr     = agc_addr_e'(reg_addr);
        wr_ctrl = reg_wr && (adr == ADR_CTRL);
        wr_ihi  = reg_wr && (adr == ADR_IHI);
        wr_ilo  = reg_wr && (adr == ADR_ILO);
        wr_tgt  = reg_wr && (adr == ADR_TGT);
        st_d      = st_q;
        st_d.ovld = in_valid;
        if (wr_ctrl) st_d.code = reg_wdata[7:5];
        if (wr_tgt)  st_d.tgt  = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (adr)
            ADR_CTRL: reg_rdata = {st_q.code, 5'b0};
            ADR_IHI:  reg_rdata = intg[INT_W-1:GAIN_W];
            ADR_ILO:  reg_rdata = intg[GAIN_W-1:0];
            default:  reg_rdata = st_q.tgt;
        endcase
    end

    agc_power_est #(.DW(DATA_W), .AW(AVG_W), .SH(LEAK_SH)) u_pwr (
        .clk(clk), .rst_n(rst_n), .vld(in_valid),
        .smp_i(in_i), .smp_q(in_q), .avg(avg)
    );

    agc_coef_dec #(.SH_W(SH_W)) u_dec (
        .code(st_q.code), .en(dec_en), .shift(dec_shift)
    );

    agc_integrator #(
        .AW(AVG_W), .IW(INT_W), .TGT_W(BYTE_W), .TGT_SH(TGT_SH),
        .ERR_SH(ERR_SH), .SH_W(SH_W), .MAX_SH(MAX_SHIFT), .RST_VAL(INT_RST)
    ) u_int (
        .clk(clk), .rst_n(rst_n), .vld(in_valid), .avg(avg), .tgt(st_q.tgt),
        .en(dec_en), .shift(dec_shift), .wr_hi(wr_ihi), .wr_lo(wr_ilo),
        .wdata(reg_wdata), .intg(intg)
    );

    assign lane_x[0] = in_i;
    assign lane_x[1] = in_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        agc_gain_mult #(.DW(DATA_W), .GW(GAIN_W), .FRAC(FRAC_W)) u_mul (
            .clk(clk), .rst_n(rst_n), .vld(in_valid), .x(lane_x[g]),
            .gain(intg[INT_W-1:GAIN_W]), .y(lane_y[g])
        );
    end

    assign out_i     = lane_y[0];
    assign out_q     = lane_y[1];
    assign out_valid = st_q.ovld;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_code_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> st_q.code == $past(reg_wdata[7:5]));
endmodule

// File: tb/sig_agc_tb_top.sv
`timescale 1ns/1ps
module sig_agc_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_i = '0;
    logic [7:0] in_q = '0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic out_valid;
    logic [7:0] out_i;
    logic [7:0] out_q;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    int m_avg, m_int, m_code, m_tgt, m_ov, m_oi, m_oq;

    always #2.5 clk = ~clk;

    sig_agc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int f_avg(int a, int i, int q);
        int p = i*i + q*q;
        return a + ((p - a) >>> 4);
    endfunction

    function automatic int f_beta_sh(int code);
        if (code >= 1 && code <= 5) return 2*(code-1);
        return -1;
    endfunction

    function automatic int f_int(int g, int a, int tgt, int code);
        int sh = f_beta_sh(code);
        int err, s;
        if (sh < 0) return g;
        err = tgt*64 - a;
        s = g + ((err * (1 << sh)) >>> 8);
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        return s;
    endfunction

    function automatic int f_mul(int x, int g);
        int p = (x * (g >> 8)) >>> 6;
        if (p > 127) p = 127;
        if (p < -128) p = -128;
        return p;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, int i, int q, bit wr, int adr, int wd);
        int n_avg, n_int, n_code, n_tgt;
        in_valid = v; in_i = 8'(i); in_q = 8'(q);
        reg_wr = wr; reg_addr = 2'(adr); reg_wdata = 8'(wd);
        n_avg = v ? f_avg(m_avg, i, q) : m_avg;
        if (wr && adr == 1)      n_int = (wd & 255) << 8;
        else if (wr && adr == 2) n_int = (m_int & 16'hFF00) | (wd & 255);
        else if (v)              n_int = f_int(m_int, m_avg, m_tgt, m_code);
        else                     n_int = m_int;
        n_code = (wr && adr == 0) ? ((wd >> 5) & 7) : m_code;
        n_tgt  = (wr && adr == 3) ? (wd & 255) : m_tgt;
        if (v) begin
            m_oi = f_mul(i, m_int);
            m_oq = f_mul(q, m_int);
        end
        m_ov = v;
        m_avg = n_avg; m_int = n_int; m_code = n_code; m_tgt = n_tgt;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; reg_wr = 0;
        chk(v ? "R8" : "R9", int'(out_valid), m_ov, "out_valid");
        chk(v ? "R8" : "R9", int'($signed(out_i)), m_oi, "out_i");
        chk(v ? "R8" : "R9", int'($signed(out_q)), m_oq, "out_q");
    endtask

    task automatic rd(string tag, int adr, int exp);
        reg_wr = 0; reg_addr = 2'(adr);
        #1;
        chk(tag, int'(reg_rdata), exp, $sformatf("read addr %0d", adr));
    endtask

    task automatic rd_int(string tag);
        rd(tag, 1, (m_int >> 8) & 255);
        rd(tag, 2, m_int & 255);
    endtask

    function automatic int rnd_s8();
        return int'($urandom % 256) - 128;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240);
        m_avg = 0; m_int = 16'h4000; m_code = 0; m_tgt = 0;
        m_ov = 0; m_oi = 0; m_oq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1", int'(out_valid), 0, "out_valid");
        chk("R1", int'(out_i), 0, "out_i");
        chk("R1", int'(out_q), 0, "out_q");
        rd("R1", 0, 0); rd("R1", 1, 8'h40); rd("R1", 2, 0); rd("R1", 3, 0);

        // R2 control byte keeps only the code
        step(0, 0, 0, 1, 0, 8'hFF);
        rd("R2", 0, 8'hE0);
        step(0, 0, 0, 1, 3, 8'h5C);
        rd("R2", 3, 8'h5C);
        step(0, 0, 0, 1, 0, 8'h00);

        // R8 unity gain pass-through, code 0 holds
        step(1, 100, -128, 0, 0, 0);
        chk("R8", int'($signed(out_i)), 100, "unity I");
        chk("R8", int'($signed(out_q)), -128, "unity Q");
        rd_int("R5");

        // R8 saturation with gain byte 0xFF; R7 high write clears low byte
        step(0, 0, 0, 1, 2, 8'h33);
        step(0, 0, 0, 1, 1, 8'hFF);
        rd("R7", 1, 8'hFF); rd("R7", 2, 8'h00);
        step(1, 100, -100, 0, 0, 0);
        chk("R8", int'($signed(out_i)), 127, "sat high");
        chk("R8", int'($signed(out_q)), -128, "sat low");
        step(0, 0, 0, 1, 2, 8'h5A);
        rd("R7", 2, 8'h5A); rd("R7", 1, 8'hFF);
        step(0, 0, 0, 1, 1, 8'h40);
        rd("R7", 2, 8'h00);

        // R9 idle keeps outputs
        step(0, 7, 7, 0, 0, 0);
        chk("R9", int'($signed(out_q)), -128, "hold Q");

        // R5 / R4 hold for codes 0, 6, 7
        for (int c = 0; c < 3; c++) begin
            step(0, 0, 0, 1, 0, (c == 0) ? 8'h00 : ((c == 1) ? 8'hC0 : 8'hE0));
            for (int k = 0; k < 12; k++) step(1, rnd_s8(), rnd_s8(), 0, 0, 0);
            rd("R5", 1, 8'h40); rd("R5", 2, 0);
        end

        // R4 / R3 each gain code, one update from known state
        step(0, 0, 0, 1, 3, 8'h30);
        for (int c = 1; c <= 5; c++) begin
            step(0, 0, 0, 1, 0, c << 5);
            step(0, 0, 0, 1, 1, 8'h80);
            step(1, 60, -40, 0, 0, 0);
            step(1, -20, 90, 0, 0, 0);
            rd_int("R4");
        end

        // R7 write wins over loop update in same cycle
        step(1, 50, 50, 1, 1, 8'h22);
        rd("R7", 1, 8'h22); rd("R7", 2, 0);

        // R6 upper clamp
        step(0, 0, 0, 1, 3, 8'hFF);
        step(0, 0, 0, 1, 0, 8'hA0);
        step(0, 0, 0, 1, 1, 8'hFF);
        for (int k = 0; k < 20; k++) step(1, 0, 0, 0, 0, 0);
        rd("R6", 1, 8'hFF); rd("R6", 2, 8'hFF);

        // R6 lower clamp, then gain zero gives zero output
        step(0, 0, 0, 1, 3, 8'h00);
        for (int k = 0; k < 40; k++) step(1, 127, 127, 0, 0, 0);
        rd("R6", 1, 0); rd("R6", 2, 0);
        step(1, 127, -128, 0, 0, 0);
        chk("R8", int'($signed(out_i)), 0, "zero gain I");

        // R3 R6 random mix
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 100);
            bit v = ($urandom % 4) != 0;
            int wr_a;
            bit w;
            w = 1; wr_a = 0;
            if (r < 5) wr_a = 0;
            else if (r < 9) wr_a = 3;
            else if (r < 11) wr_a = 1;
            else if (r < 12) wr_a = 2;
            else w = 0;
            step(v, rnd_s8(), rnd_s8(), w, wr_a, int'($urandom % 256));
            if (n % 50 == 49) begin
                rd_int("R3");
                rd("R2", 0, m_code << 5);
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule